// File: doc/BRIEF.md
# ROM Range CRC-16 Integrity Checker

This block checks that a range of read-only memory holds the expected image. After a start strobe it walks a contiguous byte range of a ROM-style read port, one address per clock in ascending order, and folds each returned byte into a seeded 16-bit CRC. The CRC update uses only XORs and fixed shifts. Unlike an additive checksum, it still changes when the range holds long runs of zero bytes.

When the last byte has been folded in, the block compares the CRC with a reference word that was captured at start. It then raises done together with exactly one of a match flag and a mismatch flag. The final CRC stays on an output until the next accepted start, so a production harness can read the value of a known-good image and keep it as the reference. A request whose range would cross the top of the address window is rejected without any read. A zero-length request completes at once with the seed value.

Top module: `rom_crc_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, done, rom_rd, crc_ok, crc_bad and range_err are 0 and crc_value is 16'hFFFF.
- R2: The CRC is seeded with 16'hFFFF. For each byte b, working in 8-bit values: t = b ^ crc[7:0], then t = t ^ (t >> 3'd4). The new crc[7:0] is (t << 4) ^ crc[15:8] ^ (t >> 3) and the new crc[15:8] is (t << 5) ^ t.
- R3: For a request of N >= 1 bytes at start address S, rom_rd is high for exactly N consecutive cycles, presenting addresses S, S+1, ..., S+N-1. rom_data is taken one cycle after the cycle in which its address was presented.
- R4: If start is sampled at rising edge k for N >= 1 bytes, then done is first high after edge k+N+1, and rom_rd is never high while done is high.
- R5: While done is high, exactly one of crc_ok and crc_bad is high. crc_ok means that crc_value equals the reference captured at start. Neither flag is high while done is low.
- R6: A request with length 0 completes after the accepting edge itself, issues no read, and leaves crc_value = 16'hFFFF; crc_ok is high only if the reference is 16'hFFFF.
- R7: A request with start address + length greater than 2^ADDR_W is rejected after the accepting edge: done, range_err and crc_bad go high, crc_value is 16'hFFFF and no read is issued. A request ending exactly at 2^ADDR_W runs normally.
- R8: A start pulse while busy is high is ignored. This includes the cycle in which the last byte is absorbed: the running check's result is unchanged.
- R9: crc_value, done and the verdict flags hold their values until the next accepted start. A start while done is high is accepted and clears done and range_err.
- R10: Every zero byte changes the CRC: ranges of one and of two zero bytes give results that differ from each other and from 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted when not busy |
| start_addr | input | ADDR_W | First byte address of the range |
| byte_len | input | ADDR_W+1 | Number of bytes in the range |
| ref_crc | input | 16 | Expected CRC, captured at start |
| rom_addr | output | ADDR_W | Read address to the ROM |
| rom_rd | output | 1 | Read strobe; data returns one cycle later |
| rom_data | input | 8 | Byte returned by the ROM |
| busy | output | 1 | Range walk in progress |
| done | output | 1 | Result valid, held until next start |
| crc_value | output | 16 | Running and then final CRC |
| crc_ok | output | 1 | Final CRC equals reference |
| crc_bad | output | 1 | Final CRC differs or range rejected |
| range_err | output | 1 | Range crossed the address window |

## Verification
In the same cycle, the last returned byte is folded into the CRC and a new start strobe can arrive. The bench provokes this by raising start in exactly the cycle of that last absorption, and also a few cycles earlier in the walk. It judges the run by the completion cycle, the final CRC and the verdict, which must match an undisturbed run. A start in the first cycle after done must then be accepted normally. Boundary ranges ending exactly at the window top, ranges one byte past it, zero-length ranges and zero-filled ranges are compared against a CRC model computed in the bench.

// File: rtl/rom_crc_pkg.sv
package rom_crc_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/crc16_byte_step.sv
// One byte of the shift/XOR CRC update, purely combinational.
module crc16_byte_step
  import rom_crc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [BYTE_W-1:0] mix0;
  logic [BYTE_W-1:0] mix1;
  logic [BYTE_W-1:0] low_b;
  logic [BYTE_W-1:0] high_b;

  always_comb begin
    mix0   = byte_in ^ crc_in[7:0];
    mix1   = mix0 ^ (mix0 >> 4);
    low_b  = (mix1 << 4) ^ crc_in[15:8] ^ (mix1 >> 3);
    high_b = (mix1 << 5) ^ mix1;
    crc_out = {high_b, low_b};
  end
endmodule

// File: rtl/rom_fetch_seq.sv
// Issues a burst of consecutive ROM reads, one per cycle.
module rom_fetch_seq #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  count,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_rd
);
  logic [LEN_W-1:0] issue_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr   <= '0;
      rom_rd     <= 1'b0;
      issue_left <= '0;
    end else if (load) begin
      rom_addr   <= base;
      rom_rd     <= (count != '0);
      issue_left <= count - 1'b1;
    end else if (rom_rd) begin
      if (issue_left != '0) begin
        rom_addr   <= rom_addr + 1'b1;
        issue_left <= issue_left - 1'b1;
      end else begin
        rom_rd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_accum.sv
// Holds the CRC register and counts the bytes still to arrive.
module crc_accum
  import rom_crc_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [LEN_W-1:0]  count,
  input  logic              vld,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q,
  output logic [CRC_W-1:0]  crc_nxt,
  output logic              last
);
  logic [LEN_W-1:0] recv_left;

  crc16_byte_step u_step (
    .crc_in  (crc_q),
    .byte_in (data),
    .crc_out (crc_nxt)
  );

  assign last = vld && (recv_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q     <= CRC_SEED;
      recv_left <= '0;
    end else if (init) begin
      crc_q     <= CRC_SEED;
      recv_left <= count;
    end else if (vld) begin
      crc_q     <= crc_nxt;
      recv_left <= recv_left - 1'b1;
    end
  end
endmodule

// File: rtl/rom_crc_checker.sv
module rom_crc_checker
  import rom_crc_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [CRC_W-1:0]  ref_crc,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              busy,
  output logic              done,
  output logic [CRC_W-1:0]  crc_value,
  output logic              crc_ok,
  output logic              crc_bad,
  output logic              range_err
);
  localparam int SUM_W = ADDR_W + 2;
  localparam logic [SUM_W-1:0] WINDOW = {2'b01, {ADDR_W{1'b0}}};

  ctl_state_e       st;
  logic             accept;
  logic             go;
  logic             is_zero;
  logic             is_over;
  logic [SUM_W-1:0] span_end;
  logic [CRC_W-1:0] ref_q;
  logic             data_vld;
  logic [CRC_W-1:0] crc_nxt;
  logic             last_byte;

  always_comb begin
    span_end = {2'b00, start_addr} + {1'b0, byte_len};
    is_over  = span_end > WINDOW;
    is_zero  = (byte_len == '0);
    accept   = start && (st == CTL_IDLE);
    go       = accept && !is_over && !is_zero;
  end

  rom_fetch_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .base     (start_addr),
    .count    (byte_len),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd)
  );

  crc_accum #(.LEN_W(LEN_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .init    (accept),
    .count   (byte_len),
    .vld     (data_vld),
    .data    (rom_data),
    .crc_q   (crc_value),
    .crc_nxt (crc_nxt),
    .last    (last_byte)
  );

  assign busy = (st == CTL_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CTL_IDLE;
      ref_q     <= '0;
      data_vld  <= 1'b0;
      done      <= 1'b0;
      crc_ok    <= 1'b0;
      crc_bad   <= 1'b0;
      range_err <= 1'b0;
    end else begin
      data_vld <= rom_rd;
      if (accept) begin
        ref_q     <= ref_crc;
        st        <= go ? CTL_RUN : CTL_IDLE;
        done      <= is_over || is_zero;
        range_err <= is_over;
        crc_ok    <= !is_over && is_zero && (ref_crc == CRC_SEED);
        crc_bad   <= is_over || (is_zero && (ref_crc != CRC_SEED));
      end else if ((st == CTL_RUN) && last_byte) begin
        st      <= CTL_IDLE;
        done    <= 1'b1;
        crc_ok  <= (crc_nxt == ref_q);
        crc_bad <= (crc_nxt != ref_q);
      end
    end
  end
endmodule

// File: rtl/rom_crc_checker_sva.sv
module rom_crc_checker_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_rd,
  input logic              busy,
  input logic              done,
  input logic [15:0]       crc_value,
  input logic              crc_ok,
  input logic              crc_bad,
  input logic              range_err
);
  // R3
  rd_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    rom_rd |-> busy);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && $past(rom_rd)) |-> (rom_addr == $past(rom_addr) + 1'b1));

  // R4
  no_read_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rom_rd && !busy));

  // R5
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (crc_ok ^ crc_bad));

  // R5
  no_early_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (!crc_ok && !crc_bad));

  // R7
  range_flag_chk: assert property (@(posedge clk) disable iff (rst)
    range_err |-> (done && crc_bad && crc_value == 16'hFFFF));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(crc_value) && $stable(crc_ok)));
endmodule

bind rom_crc_checker rom_crc_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .rom_addr  (rom_addr),
  .rom_rd    (rom_rd),
  .busy      (busy),
  .done      (done),
  .crc_value (crc_value),
  .crc_ok    (crc_ok),
  .crc_bad   (crc_bad),
  .range_err (range_err)
);

// File: tb/tb_rom_crc_checker.sv
`timescale 1ns/1ps
module tb_rom_crc_checker;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = ADDR_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  byte_len = '0;
  logic [15:0]       ref_crc = '0;
  logic [ADDR_W-1:0] rom_addr;
  logic              rom_rd;
  logic [7:0]        rom_data = '0;
  logic              busy, done, crc_ok, crc_bad, range_err;
  logic [15:0]       crc_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rom_crc_checker #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_len(byte_len), .ref_crc(ref_crc), .rom_addr(rom_addr),
    .rom_rd(rom_rd), .rom_data(rom_data), .busy(busy), .done(done),
    .crc_value(crc_value), .crc_ok(crc_ok), .crc_bad(crc_bad),
    .range_err(range_err)
  );

  // ROM image: page 01xxh is all zeros, the rest is a computed pattern.
  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    logic [7:0] v;
    if (a[15:8] == 8'h01) return 8'h00;
    v = a[7:0] * 8'd37;
    return v ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] model_crc(input logic [15:0] a0, input int n);
    logic [15:0] c;
    logic [7:0]  t, h, l;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      t = rom_byte(a0 + 16'(i)) ^ c[7:0];
      t = t ^ (t >> 4);
      l = (t << 4) ^ c[15:8] ^ (t >> 3);
      h = (t << 5) ^ t;
      c = {h, l};
    end
    return c;
  endfunction

  always @(posedge clk) if (rom_rd) rom_data <= rom_byte(rom_addr);

  // Read-order monitor (R3)
  int          rd_cnt = 0;
  int          seq_err = 0;
  logic [15:0] exp_addr = '0;
  always @(posedge clk) begin
    cycles++;
    if (!rst && rom_rd) begin
      if (rom_addr != exp_addr) seq_err++;
      exp_addr = rom_addr + 16'd1;
      rd_cnt++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  int          got_cyc;
  logic [15:0] got_crc;
  logic        got_ok, got_bad, got_rng;

  // Start a request at a negedge; optionally poke a zero-length start
  // when poke_at edges have passed since acceptance.
  task automatic run(input logic [15:0] s, input logic [16:0] n,
                     input logic [15:0] r, input int poke_at);
    int cnt;
    @(negedge clk);
    rd_cnt = 0; seq_err = 0; exp_addr = s;
    start = 1'b1; start_addr = s; byte_len = n; ref_crc = r;
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (cnt == poke_at) begin
        start = 1'b1; start_addr = 16'h0000; byte_len = '0; ref_crc = 16'hFFFF;
      end
      if (done && start == 1'b0) break;
      if (cnt > 3000) begin
        chk(1'b0, "R4 timeout", 32'(cnt), 32'(n));
        break;
      end
      @(posedge clk);
      cnt++;
    end
    got_cyc = cnt; got_crc = crc_value;
    got_ok = crc_ok; got_bad = crc_bad; got_rng = range_err;
  endtask

  task automatic check_run(input logic [15:0] s, input logic [16:0] n,
                           input logic good, input int poke_at);
    logic [15:0] e;
    e = model_crc(s, int'(n));
    run(s, n, good ? e : (e ^ 16'h0001), poke_at);
    chk(got_crc == e, "R2 crc value", 32'(got_crc), 32'(e));
    chk(got_cyc == int'(n) + 1, "R4 completion cycle", 32'(got_cyc), 32'(n) + 1);
    chk(rd_cnt == int'(n) && seq_err == 0, "R3 read sequence", 32'(rd_cnt), 32'(n));
    chk(got_ok == good && got_bad == !good && !got_rng, "R5 verdict",
        {29'd0, got_ok, got_bad, got_rng}, {29'd0, good, !good, 1'b0});
  endtask

  // {start address, length, reference is good}
  localparam logic [33:0] VEC [6] = '{
    {16'h0000, 17'd1,     1'b1},
    {16'h0010, 17'd16,    1'b1},
    {16'h0100, 17'd32,    1'b1},
    {16'h1234, 17'd5,     1'b0},
    {16'hFFF0, 17'd16,    1'b1},
    {16'h0200, 17'd100,   1'b0}
  };

  initial begin : watchdog
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected <100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] z1, z2, held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !rom_rd && !crc_ok && !crc_bad && !range_err && crc_value == 16'hFFFF,
        "R1 in reset", {26'd0, busy, done, rom_rd, crc_ok, crc_bad, range_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rom_rd && crc_value == 16'hFFFF, "R1 after reset",
        {16'd0, crc_value}, 32'h0000FFFF);

    foreach (VEC[i]) check_run(VEC[i][33:18], VEC[i][17:1], VEC[i][0], -1);

    // R6 zero length
    run(16'h0300, 17'd0, 16'hFFFF, -1);
    chk(got_cyc == 0 && got_crc == 16'hFFFF && got_ok && !got_bad && rd_cnt == 0,
        "R6 zero length match", {got_crc, 8'(got_cyc), 8'(rd_cnt)}, 32'hFFFF0000);
    run(16'h0300, 17'd0, 16'h0000, -1);
    chk(got_cyc == 0 && !got_ok && got_bad, "R6 zero length mismatch",
        {30'd0, got_ok, got_bad}, 32'd1);

    // R7 one byte past the window
    run(16'hFFF0, 17'd17, 16'h0000, -1);
    chk(got_cyc == 0 && got_rng && got_bad && !got_ok && rd_cnt == 0 && got_crc == 16'hFFFF,
        "R7 window reject", {got_crc, 13'd0, got_rng, got_bad, got_ok}, 32'hFFFF0006);
    run(16'h0000, 17'h10000 + 17'd1, 16'h0000, -1);
    chk(got_rng && rd_cnt == 0, "R7 oversize length", 32'(rd_cnt), 32'd0);

    // R9 start while done clears range_err and runs normally
    check_run(16'h0040, 17'd3, 1'b1, -1);
    chk(!got_rng, "R9 range_err cleared", 32'(got_rng), 32'd0);

    // R9 hold after done
    held = crc_value;
    repeat (6) @(negedge clk);
    chk(done && crc_value == held && crc_ok, "R9 result held",
        {15'd0, done, crc_value}, {15'd0, 1'b1, held});

    // R8 start mid-run and in the last-absorption cycle
    check_run(16'h0040, 17'd20, 1'b1, 5);
    check_run(16'h0050, 17'd12, 1'b0, 12);
    // R9 next start right after done
    check_run(16'h0060, 17'd4, 1'b1, -1);

    // R10 zero runs
    run(16'h0100, 17'd1, 16'h0000, -1); z1 = got_crc;
    run(16'h0100, 17'd2, 16'h0000, -1); z2 = got_crc;
    chk(z1 != z2 && z1 != 16'hFFFF && z2 != 16'hFFFF, "R10 zero bytes change crc",
        {z1, z2}, 32'hFFFFFFFF);
    chk(z2 == model_crc(16'h0100, 2), "R10 two zeros value", 32'(z2), 32'(model_crc(16'h0100, 2)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule